// File: doc/BRIEF.md
# Two-Pipe Four-Layer Pixel Compositor

This block builds one output pixel per cycle from up to four layer pixels that arrive in parallel with the raster position. Composition happens in two stages. First, every enabled layer whose rectangle contains the current position competes inside the pipe it is bound to, and the layer with the highest priority wins without any mixing. Second, the pipe 1 winner is alpha-blended over the pipe 0 result. The background colour fills any pixel that no layer of a pipe covers.

The active layer settings are a shadow copy of the configuration inputs. Software drives new settings and pulses a commit request. The settings are copied into the active set at the next vertical-blank pulse, and the pending flag then clears by itself. A run gate requires both an enable input and a start input. A route input sends the composed stream to one of two display timing outputs. An optional fault mode mimics hardware where a translucent lowest-priority pixel in pipe 0 is dropped in favour of the background.

Top module: `dual_pipe_compositor`

## Requirements
- R1: After reset, the pending flag is 0, both valid outputs are 0, the pixel output is 0, and all active layers are disabled, so a running block outputs only the background colour until the first commit is applied.
- R2: Layer i covers position (x,y) when it is active-enabled, x is at least its x origin and below origin plus width, and y is at least its y origin and below origin plus height. A width or height of zero covers nothing. Layer i uses slice i of every flattened bus (bits i*W upward, where W is the field width).
- R3: Within a pipe (pipe field 0 or 1), the covering layer with the numerically larger 2-bit priority supplies the pipe pixel unchanged. On equal priority the lower layer index wins.
- R4: The effective alpha of a layer is (pixelAlpha*globalAlpha+127)/255 with integer division. When pipe 1 has a winner with effective alpha a, each 8-bit channel (bits 23:16, 15:8, 7:0) of the output is (a*top+(255-a)*bottom+127)/255, where top is the pipe 1 pixel and bottom is the pipe 0 result.
- R5: The pipe 0 result is the background colour when no pipe 0 layer covers the position. When no pipe 1 layer covers the position, the output equals the pipe 0 result. The effective alpha of pipe 0 is not used.
- R6: With quirkMode set, if the pipe 0 winner has priority 0 and effective alpha below 255, the pipe 0 result is the background colour.
- R7: Changes to the configuration inputs have no effect until commitSet is sampled high and a later vblank is sampled while the flag is pending. Pixels sampled in the cycle after that vblank use the new settings. commitBusy rises the cycle after commitSet and falls the cycle after the applying vblank, unless commitSet is high again in that vblank cycle.
- R8: An output pixel is valid only when modEn, startEn and pixValid were all high at its input sample. Otherwise both valid outputs are 0 and outPix is 0.
- R9: With outSel 0 a valid pixel raises outValid0. With outSel 1 it raises outValid1. Both are never high together.
- R10: Pixel, valid and route results appear two clock edges after the input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| modEn | input | 1 | Module enable |
| startEn | input | 1 | Start control, needed with modEn to produce output |
| outSel | input | 1 | Selects display output 0 or 1 |
| quirkMode | input | 1 | Enables the translucent-lowest-layer drop behaviour |
| bgColor | input | 24 | Background colour, RGB 8:8:8 |
| commitSet | input | 1 | Request to apply the configuration at the next vblank |
| vblank | input | 1 | Vertical-blank pulse |
| cfgEnable | input | 4 | Per-layer enable (shadow) |
| cfgPipe | input | 4 | Per-layer pipe select (shadow) |
| cfgPrio | input | 8 | Per-layer 2-bit priority (shadow) |
| cfgXpos | input | 48 | Per-layer x origin (shadow) |
| cfgYpos | input | 48 | Per-layer y origin (shadow) |
| cfgWidth | input | 48 | Per-layer width (shadow) |
| cfgHeight | input | 48 | Per-layer height (shadow) |
| cfgGlobalAlpha | input | 32 | Per-layer global alpha (shadow) |
| pixIn | input | 96 | Per-layer RGB pixel for the current position |
| alphaIn | input | 32 | Per-layer pixel alpha |
| pixValid | input | 1 | Current position carries a pixel |
| xCnt | input | 12 | Current x position |
| yCnt | input | 12 | Current y position |
| commitBusy | output | 1 | Commit request pending |
| outValid0 | output | 1 | Valid pixel routed to output 0 |
| outValid1 | output | 1 | Valid pixel routed to output 1 |
| outPix | output | 24 | Composed pixel |

## Verification
A composed pixel, its valid bit and its route are due on the second rising edge after the inputs are sampled. commitBusy is due on the first edge, and a committed configuration governs the pixels sampled on the edge after the applying vblank. The reference model computes each expectation when the inputs are driven on a falling edge and queues it. It updates its own pending flag and active settings as the register stage would. It compares the pixel outputs against the entry queued two falling edges earlier, and commitBusy against its state after one edge. All samples are taken on falling edges, away from the edges that update the design.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int CHW = 8;
  localparam int NCH = 3;
  localparam int PIXW = CHW * NCH;
  localparam int AW = 8;
  localparam int NUM_PIPES = 2;

  typedef struct packed {
    logic load;
    logic run;
    logic route;
  } ctrl_strobe_t;

  function automatic logic [AW-1:0] scaleAlpha(input logic [AW-1:0] pa, input logic [AW-1:0] ga);
    logic [2*AW:0] prod;
    prod = (2*AW+1)'(pa) * (2*AW+1)'(ga) + (2*AW+1)'(127);
    return AW'(prod / (2*AW+1)'(255));
  endfunction

  function automatic logic [CHW-1:0] blendChan(input logic [AW-1:0] a, input logic [CHW-1:0] top,
                                               input logic [CHW-1:0] bot);
    logic [2*CHW:0] acc;
    acc = (2*CHW+1)'(a) * (2*CHW+1)'(top)
        + (2*CHW+1)'(8'd255 - a) * (2*CHW+1)'(bot)
        + (2*CHW+1)'(127);
    return CHW'(acc / (2*CHW+1)'(255));
  endfunction
endpackage

// File: rtl/comp_ctrl.sv
module comp_ctrl
  import comp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modEn,
  input  logic         startEn,
  input  logic         outSel,
  input  logic         commitSet,
  input  logic         vblank,
  output ctrl_strobe_t strobe,
  output logic         commitBusy
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= commitSet | (pending & ~vblank);
  end

  always_comb begin
    strobe.load  = vblank & pending;
    strobe.run   = modEn & startEn;
    strobe.route = outSel;
  end

  assign commitBusy = pending;
endmodule

// File: rtl/comp_datapath.sv
module comp_datapath
  import comp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int CW = 12,
  parameter int PRW = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobe_t               strobe,
  input  logic                       quirkMode,
  input  logic [PIXW-1:0]            bgColor,
  input  logic [NUM_LAYERS-1:0]      cfgEnable,
  input  logic [NUM_LAYERS-1:0]      cfgPipe,
  input  logic [NUM_LAYERS*PRW-1:0]  cfgPrio,
  input  logic [NUM_LAYERS*CW-1:0]   cfgXpos,
  input  logic [NUM_LAYERS*CW-1:0]   cfgYpos,
  input  logic [NUM_LAYERS*CW-1:0]   cfgWidth,
  input  logic [NUM_LAYERS*CW-1:0]   cfgHeight,
  input  logic [NUM_LAYERS*AW-1:0]   cfgGlobalAlpha,
  input  logic [NUM_LAYERS*PIXW-1:0] pixIn,
  input  logic [NUM_LAYERS*AW-1:0]   alphaIn,
  input  logic                       pixValid,
  input  logic [CW-1:0]              xCnt,
  input  logic [CW-1:0]              yCnt,
  output logic                       outValid0,
  output logic                       outValid1,
  output logic [PIXW-1:0]            outPix
);
  localparam int IW = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1;

  // Active (committed) layer settings
  logic          actEn   [NUM_LAYERS];
  logic          actPipe [NUM_LAYERS];
  logic [PRW-1:0] actPrio[NUM_LAYERS];
  logic [CW-1:0] actX    [NUM_LAYERS];
  logic [CW-1:0] actY    [NUM_LAYERS];
  logic [CW-1:0] actW    [NUM_LAYERS];
  logic [CW-1:0] actH    [NUM_LAYERS];
  logic [AW-1:0] actGA   [NUM_LAYERS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_LAYERS; i++) begin
      if (!rstN) begin
        actEn[i]   <= 1'b0;
        actPipe[i] <= 1'b0;
        actPrio[i] <= '0;
        actX[i]    <= '0;
        actY[i]    <= '0;
        actW[i]    <= '0;
        actH[i]    <= '0;
        actGA[i]   <= '0;
      end else if (strobe.load) begin
        actEn[i]   <= cfgEnable[i];
        actPipe[i] <= cfgPipe[i];
        actPrio[i] <= cfgPrio[i*PRW +: PRW];
        actX[i]    <= cfgXpos[i*CW +: CW];
        actY[i]    <= cfgYpos[i*CW +: CW];
        actW[i]    <= cfgWidth[i*CW +: CW];
        actH[i]    <= cfgHeight[i*CW +: CW];
        actGA[i]   <= cfgGlobalAlpha[i*AW +: AW];
      end
    end
  end

  // Per-layer coverage and effective alpha
  logic [NUM_LAYERS-1:0] hit;
  logic [AW-1:0]   effA   [NUM_LAYERS];
  logic [PIXW-1:0] layPix [NUM_LAYERS];

  for (genvar gi = 0; gi < NUM_LAYERS; gi++) begin : g_layer
    logic [CW:0] xEnd;
    logic [CW:0] yEnd;
    logic inX;
    logic inY;
    assign xEnd = {1'b0, actX[gi]} + {1'b0, actW[gi]};
    assign yEnd = {1'b0, actY[gi]} + {1'b0, actH[gi]};
    assign inX  = ({1'b0, xCnt} >= {1'b0, actX[gi]}) && ({1'b0, xCnt} < xEnd);
    assign inY  = ({1'b0, yCnt} >= {1'b0, actY[gi]}) && ({1'b0, yCnt} < yEnd);
    assign hit[gi]    = actEn[gi] && inX && inY;
    assign effA[gi]   = scaleAlpha(alphaIn[gi*AW +: AW], actGA[gi]);
    assign layPix[gi] = pixIn[gi*PIXW +: PIXW];
  end

  // Priority selection inside each pipe
  logic          selHit [NUM_PIPES];
  logic [IW-1:0] selIdx [NUM_PIPES];

  always_comb begin
    for (int p = 0; p < NUM_PIPES; p++) begin
      selHit[p] = 1'b0;
      selIdx[p] = '0;
      for (int i = 0; i < NUM_LAYERS; i++) begin
        if (hit[i] && (actPipe[i] == 1'(p)) &&
            (!selHit[p] || (actPrio[i] > actPrio[selIdx[p]]))) begin
          selHit[p] = 1'b1;
          selIdx[p] = IW'(i);
        end
      end
    end
  end

  // Bottom pipe result with the drop fault applied
  logic            dropLow;
  logic [PIXW-1:0] bottomPix;

  always_comb begin
    dropLow   = quirkMode && selHit[0] && (actPrio[selIdx[0]] == '0) &&
                (effA[selIdx[0]] != {AW{1'b1}});
    bottomPix = (selHit[0] && !dropLow) ? layPix[selIdx[0]] : bgColor;
  end

  // Stage 1 registers
  logic            s1Valid;
  logic            s1Route;
  logic            s1TopHit;
  logic [PIXW-1:0] s1Bottom;
  logic [PIXW-1:0] s1Top;
  logic [AW-1:0]   s1Alpha;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Route  <= 1'b0;
      s1TopHit <= 1'b0;
      s1Bottom <= '0;
      s1Top    <= '0;
      s1Alpha  <= '0;
    end else begin
      s1Valid  <= strobe.run & pixValid;
      s1Route  <= strobe.route;
      s1TopHit <= selHit[1];
      s1Bottom <= bottomPix;
      s1Top    <= layPix[selIdx[1]];
      s1Alpha  <= effA[selIdx[1]];
    end
  end

  // Stage 2: blend between the pipes
  logic [PIXW-1:0] blended;

  for (genvar gc = 0; gc < NCH; gc++) begin : g_chan
    assign blended[gc*CHW +: CHW] =
      blendChan(s1Alpha, s1Top[gc*CHW +: CHW], s1Bottom[gc*CHW +: CHW]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid0 <= 1'b0;
      outValid1 <= 1'b0;
      outPix    <= '0;
    end else begin
      outValid0 <= s1Valid & ~s1Route;
      outValid1 <= s1Valid & s1Route;
      outPix    <= !s1Valid ? '0 : (s1TopHit ? blended : s1Bottom);
    end
  end
endmodule

// File: rtl/dual_pipe_compositor.sv
module dual_pipe_compositor
  import comp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int CW = 12,
  parameter int PRW = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       modEn,
  input  logic                       startEn,
  input  logic                       outSel,
  input  logic                       quirkMode,
  input  logic [PIXW-1:0]            bgColor,
  input  logic                       commitSet,
  input  logic                       vblank,
  input  logic [NUM_LAYERS-1:0]      cfgEnable,
  input  logic [NUM_LAYERS-1:0]      cfgPipe,
  input  logic [NUM_LAYERS*PRW-1:0]  cfgPrio,
  input  logic [NUM_LAYERS*CW-1:0]   cfgXpos,
  input  logic [NUM_LAYERS*CW-1:0]   cfgYpos,
  input  logic [NUM_LAYERS*CW-1:0]   cfgWidth,
  input  logic [NUM_LAYERS*CW-1:0]   cfgHeight,
  input  logic [NUM_LAYERS*AW-1:0]   cfgGlobalAlpha,
  input  logic [NUM_LAYERS*PIXW-1:0] pixIn,
  input  logic [NUM_LAYERS*AW-1:0]   alphaIn,
  input  logic                       pixValid,
  input  logic [CW-1:0]              xCnt,
  input  logic [CW-1:0]              yCnt,
  output logic                       commitBusy,
  output logic                       outValid0,
  output logic                       outValid1,
  output logic [PIXW-1:0]            outPix
);
  ctrl_strobe_t strobe;

  comp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modEn(modEn), .startEn(startEn), .outSel(outSel),
    .commitSet(commitSet), .vblank(vblank), .strobe(strobe), .commitBusy(commitBusy)
  );

  comp_datapath #(.NUM_LAYERS(NUM_LAYERS), .CW(CW), .PRW(PRW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .quirkMode(quirkMode), .bgColor(bgColor),
    .cfgEnable(cfgEnable), .cfgPipe(cfgPipe), .cfgPrio(cfgPrio), .cfgXpos(cfgXpos),
    .cfgYpos(cfgYpos), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgGlobalAlpha(cfgGlobalAlpha), .pixIn(pixIn), .alphaIn(alphaIn),
    .pixValid(pixValid), .xCnt(xCnt), .yCnt(yCnt),
    .outValid0(outValid0), .outValid1(outValid1), .outPix(outPix)
  );
endmodule

// File: rtl/comp_checker.sv
module comp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        modEn,
  input logic        startEn,
  input logic        outSel,
  input logic        pixValid,
  input logic        commitSet,
  input logic        vblank,
  input logic        commitBusy,
  input logic        outValid0,
  input logic        outValid1,
  input logic [23:0] outPix
);
  // R9: a pixel goes to one output only
  assert_route_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outValid0, outValid1}));

  // R9: the output used follows the route input two edges back
  assert_route_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid1 |-> $past(outSel, 2));

  // R8: valid only when the run gate and pixValid were all high
  assert_run_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid0 || outValid1) |-> $past(modEn && startEn && pixValid, 2));

  // R8: idle output is zero
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid0 || outValid1) |-> (outPix == 24'd0));

  // R7: a commit request sets the pending flag
  assert_commit_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    commitSet |=> commitBusy);

  // R7: the pending flag clears at the applying vblank
  assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (commitBusy && vblank && !commitSet) |=> !commitBusy);

  // R7: the pending flag holds until a vblank
  assert_commit_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (commitBusy && !vblank) |=> commitBusy);
endmodule

bind dual_pipe_compositor comp_checker u_chk (
  .clk(clk), .rstN(rstN), .modEn(modEn), .startEn(startEn), .outSel(outSel),
  .pixValid(pixValid), .commitSet(commitSet), .vblank(vblank),
  .commitBusy(commitBusy), .outValid0(outValid0), .outValid1(outValid1), .outPix(outPix)
);

// File: tb/sim_dual_pipe_compositor.sv
`timescale 1ns/1ps
module sim_dual_pipe_compositor;
  localparam int NL = 4;
  localparam int CW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, modEn = 1'b0, startEn = 1'b0, outSel = 1'b0, quirkMode = 1'b0;
  logic [23:0] bgColor = '0;
  logic commitSet = 1'b0, vblank = 1'b0, pixValid = 1'b0;
  logic [NL-1:0] cfgEnable = '0, cfgPipe = '0;
  logic [NL*2-1:0] cfgPrio = '0;
  logic [NL*CW-1:0] cfgXpos = '0, cfgYpos = '0, cfgWidth = '0, cfgHeight = '0;
  logic [NL*8-1:0] cfgGlobalAlpha = '0, alphaIn = '0;
  logic [NL*24-1:0] pixIn = '0;
  logic [CW-1:0] xCnt = '0, yCnt = '0;
  logic commitBusy, outValid0, outValid1;
  logic [23:0] outPix;

  dual_pipe_compositor u0 (
    .clk(clk), .rstN(rstN), .modEn(modEn), .startEn(startEn), .outSel(outSel),
    .quirkMode(quirkMode), .bgColor(bgColor), .commitSet(commitSet), .vblank(vblank),
    .cfgEnable(cfgEnable), .cfgPipe(cfgPipe), .cfgPrio(cfgPrio), .cfgXpos(cfgXpos),
    .cfgYpos(cfgYpos), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgGlobalAlpha(cfgGlobalAlpha), .pixIn(pixIn), .alphaIn(alphaIn),
    .pixValid(pixValid), .xCnt(xCnt), .yCnt(yCnt), .commitBusy(commitBusy),
    .outValid0(outValid0), .outValid1(outValid1), .outPix(outPix)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit    v0;
    bit    v1;
    int    pix;
    string tag;
  } exp_t;
  exp_t q[$];

  // Reference state
  bit mPend = 1'b0;
  bit acEn[NL], acPipe[NL];
  int acPrio[NL], acX[NL], acY[NL], acW[NL], acH[NL], acGA[NL];

  function automatic int effA(int pa, int ga);
    return (pa * ga + 127) / 255;
  endfunction

  function automatic int pixOf(int i);
    return int'(pixIn[i*24 +: 24]);
  endfunction

  function automatic int alphaOf(int i);
    return int'(alphaIn[i*8 +: 8]);
  endfunction

  task automatic tick(string tag);
    exp_t e;
    int best[2];
    int bottom, res, a, x, y, w0;
    bit run;
    x = int'(xCnt);
    y = int'(yCnt);
    for (int p = 0; p < 2; p++) begin
      best[p] = -1;
      for (int i = 0; i < NL; i++) begin
        if (acEn[i] && int'(acPipe[i]) == p && x >= acX[i] && x < acX[i] + acW[i] &&
            y >= acY[i] && y < acY[i] + acH[i] &&
            (best[p] < 0 || acPrio[i] > acPrio[best[p]]))
          best[p] = i;
      end
    end
    bottom = int'(bgColor);
    if (best[0] >= 0) begin
      w0 = best[0];
      if (!(quirkMode && acPrio[w0] == 0 && effA(alphaOf(w0), acGA[w0]) != 255))
        bottom = pixOf(w0);
    end
    res = bottom;
    if (best[1] >= 0) begin
      a = effA(alphaOf(best[1]), acGA[best[1]]);
      res = 0;
      for (int c = 0; c < 3; c++) begin
        int t, b;
        t = (pixOf(best[1]) >> (8*c)) & 255;
        b = (bottom >> (8*c)) & 255;
        res = res | (((a*t + (255-a)*b + 127) / 255) << (8*c));
      end
    end
    run = modEn && startEn && pixValid;
    e.v0 = run && !outSel;
    e.v1 = run && outSel;
    e.pix = run ? res : 0;
    e.tag = tag;
    q.push_back(e);
    if (vblank && mPend) begin
      for (int i = 0; i < NL; i++) begin
        acEn[i]   = cfgEnable[i];
        acPipe[i] = cfgPipe[i];
        acPrio[i] = int'(cfgPrio[i*2 +: 2]);
        acX[i]    = int'(cfgXpos[i*CW +: CW]);
        acY[i]    = int'(cfgYpos[i*CW +: CW]);
        acW[i]    = int'(cfgWidth[i*CW +: CW]);
        acH[i]    = int'(cfgHeight[i*CW +: CW]);
        acGA[i]   = int'(cfgGlobalAlpha[i*8 +: 8]);
      end
    end
    mPend = commitSet || (mPend && !vblank);
    @(negedge clk);
    e = q.pop_front();
    checks++;
    if (outValid0 !== e.v0 || outValid1 !== e.v1 || outPix !== 24'(e.pix)) begin
      failures++;
      $display("FAIL %s R10: actual v0=%0b v1=%0b pix=%06h expected v0=%0b v1=%0b pix=%06h",
               e.tag, outValid0, outValid1, outPix, e.v0, e.v1, 24'(e.pix));
    end
    checks++;
    if (commitBusy !== mPend) begin
      failures++;
      $display("FAIL R7 commitBusy (%s): actual=%0b expected=%0b", tag, commitBusy, mPend);
    end
  endtask

  task automatic setLayer(int i, bit en, bit pipe, int prio, int x, int y, int w, int h, int ga);
    cfgEnable[i] = en;
    cfgPipe[i] = pipe;
    cfgPrio[i*2 +: 2] = 2'(prio);
    cfgXpos[i*CW +: CW] = CW'(x);
    cfgYpos[i*CW +: CW] = CW'(y);
    cfgWidth[i*CW +: CW] = CW'(w);
    cfgHeight[i*CW +: CW] = CW'(h);
    cfgGlobalAlpha[i*8 +: 8] = 8'(ga);
  endtask

  task automatic randLayers();
    for (int i = 0; i < NL; i++)
      setLayer(i, $urandom_range(0, 4) != 0, 1'($urandom_range(0, 1)), $urandom_range(0, 3),
               $urandom_range(0, 25), $urandom_range(0, 25), $urandom_range(0, 16),
               $urandom_range(0, 16), ($urandom_range(0, 1) != 0) ? 255 : $urandom_range(0, 255));
  endtask

  task automatic randPixels();
    pixIn = {$urandom, $urandom, $urandom};
    for (int i = 0; i < NL; i++)
      alphaIn[i*8 +: 8] = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'($urandom_range(0, 255));
    xCnt = CW'($urandom_range(0, 42));
    yCnt = CW'($urandom_range(0, 42));
  endtask

  task automatic commitCfg(string tag);
    commitSet = 1'b1;
    tick(tag);
    commitSet = 1'b0;
    tick(tag);
    vblank = 1'b1;
    tick(tag);
    vblank = 1'b0;
  endtask

  initial begin
    repeat (4000 * 40) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      acEn[i] = 0; acPipe[i] = 0; acPrio[i] = 0; acX[i] = 0;
      acY[i] = 0; acW[i] = 0; acH[i] = 0; acGA[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    begin
      exp_t z;
      z.v0 = 0; z.v1 = 0; z.pix = 0; z.tag = "R1 reset";
      q.push_back(z);
    end
    repeat (3) tick("R1 reset");

    // R1/R5: running with nothing committed shows background
    modEn = 1; startEn = 1; pixValid = 1; bgColor = 24'h102030;
    for (int k = 0; k < 6; k++) begin randPixels(); tick("R1 R5 background only"); end

    // R7: shadow settings ignored without commit, even across vblank
    for (int i = 0; i < NL; i++) setLayer(i, 1, 1'(i & 1), i, 0, 0, 60, 60, 255);
    for (int k = 0; k < 6; k++) begin
      randPixels(); vblank = (k == 2); tick("R7 no commit");
    end
    vblank = 0;
    commitSet = 1; randPixels(); tick("R7 request");
    commitSet = 0;
    for (int k = 0; k < 4; k++) begin randPixels(); tick("R7 pending"); end
    vblank = 1; randPixels(); tick("R7 apply edge");
    vblank = 0;
    for (int k = 0; k < 6; k++) begin randPixels(); tick("R7 applied"); end
    for (int i = 0; i < NL; i++) setLayer(i, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin randPixels(); tick("R7 shadow change ignored"); end
    commitSet = 1; vblank = 1; tick("R7 set with vblank");
    commitSet = 0; vblank = 0;
    for (int k = 0; k < 3; k++) begin randPixels(); tick("R7 still pending"); end
    vblank = 1; tick("R7 apply"); vblank = 0;

    // R2: rectangle edges and zero width
    setLayer(0, 1, 0, 1, 10, 3, 5, 2, 255);
    setLayer(1, 1, 0, 3, 10, 3, 0, 4, 255);
    setLayer(2, 0, 1, 0, 0, 0, 50, 50, 255);
    setLayer(3, 1, 1, 0, 12, 4, 1, 0, 255);
    commitCfg("R2 setup");
    for (int y = 2; y <= 6; y++)
      for (int x = 8; x <= 16; x++) begin
        randPixels(); xCnt = CW'(x); yCnt = CW'(y); tick("R2 edges");
      end

    // R3: equal priority tie and highest priority selection
    setLayer(0, 1, 0, 2, 0, 0, 50, 50, 255);
    setLayer(1, 1, 0, 2, 0, 0, 50, 50, 255);
    setLayer(2, 1, 0, 1, 0, 0, 50, 50, 255);
    setLayer(3, 0, 1, 3, 0, 0, 50, 50, 255);
    commitCfg("R3 setup");
    for (int k = 0; k < 8; k++) begin randPixels(); tick("R3 tie lower index"); end
    setLayer(2, 1, 0, 3, 5, 5, 10, 10, 128);
    commitCfg("R3 setup2");
    for (int k = 0; k < 12; k++) begin randPixels(); tick("R3 highest priority"); end

    // R4/R5: blend with fixed alphas, pipe0 alpha unused
    setLayer(0, 1, 0, 0, 0, 0, 50, 50, 255);
    setLayer(1, 1, 1, 0, 0, 0, 50, 50, 255);
    setLayer(2, 0, 0, 0, 0, 0, 0, 0, 0);
    setLayer(3, 0, 1, 0, 0, 0, 0, 0, 0);
    commitCfg("R4 setup");
    for (int k = 0; k < 3; k++) begin
      randPixels(); alphaIn[8 +: 8] = 8'(k * 127); alphaIn[7:0] = 8'h10; tick("R4 blend alpha");
    end
    setLayer(1, 1, 1, 0, 0, 0, 50, 50, 128);
    commitCfg("R4 setup2");
    for (int k = 0; k < 6; k++) begin randPixels(); tick("R4 global alpha"); end
    setLayer(0, 0, 0, 0, 0, 0, 0, 0, 0);
    commitCfg("R5 setup");
    for (int k = 0; k < 4; k++) begin randPixels(); tick("R5 bg under pipe1"); end

    // R6: translucent lowest pipe0 layer dropped in fault mode
    quirkMode = 1;
    setLayer(0, 1, 0, 0, 0, 0, 50, 50, 200);
    setLayer(1, 1, 1, 1, 20, 20, 10, 10, 255);
    setLayer(2, 1, 0, 1, 30, 30, 10, 10, 100);
    commitCfg("R6 setup");
    for (int k = 0; k < 16; k++) begin randPixels(); tick("R6 quirk drop"); end
    setLayer(0, 1, 0, 0, 0, 0, 50, 50, 255);
    commitCfg("R6 setup2");
    for (int k = 0; k < 10; k++) begin randPixels(); tick("R6 quirk opaque kept"); end
    for (int r = 0; r < 4; r++) begin
      randLayers(); commitCfg("R6 setup rnd");
      for (int k = 0; k < 20; k++) begin randPixels(); tick("R6 quirk random"); end
    end
    quirkMode = 0;

    // Random composition rounds
    for (int r = 0; r < 14; r++) begin
      randLayers(); bgColor = 24'($urandom);
      commitCfg("R2 R3 R4 R5 setup rnd");
      for (int k = 0; k < 40; k++) begin randPixels(); tick("R2 R3 R4 R5 R10 random"); end
    end

    // R8: run gate
    for (int k = 0; k < 40; k++) begin
      randPixels();
      modEn = 1'($urandom_range(0, 1)); startEn = 1'($urandom_range(0, 1));
      pixValid = 1'($urandom_range(0, 1));
      tick("R8 gate");
    end
    modEn = 1; startEn = 1; pixValid = 1;

    // R9: output routing
    for (int k = 0; k < 30; k++) begin
      randPixels(); outSel = 1'($urandom_range(0, 1)); tick("R9 route");
    end
    outSel = 0;
    modEn = 0;
    repeat (3) tick("R8 drain");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule